// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Acknowledge

This block receives bytes from a sender over two wires: a clock that the sender drives and a data line that both ends share. The serial clock and the data are brought into the system clock domain through a synchroniser. On each falling edge of the serial clock, one data bit enters a shift register at its low end. The register is loaded with a single marker bit at the bottom. When that marker moves past the top after eight shifts, the byte is complete. No bit counter is used.

When a byte completes, it is placed on a parallel output together with a one-cycle valid strobe. The receiver then enables its open-drain driver, which pulls the data line low for a fixed number of system clocks as an acknowledge. Serial clock edges that arrive while the acknowledge is being driven are ignored. A byte of all ones is treated as the end of the transfer and raises a flag. A synchronous reset discards any partial byte, so the receiver can be brought back into step with the sender.

Top module: `serial_byte_rx`

## Requirements
- R1: A data bit is taken only at a falling edge of the synchronised serial clock. Changes on the data line while the serial clock is high, or after the edge has been seen, have no effect on the received byte.
- R2: The first bit received becomes bit 7 of `byte_o` and the last becomes bit 0. `byte_o` changes only in a cycle where `byte_vld_o` is high.
- R3: `byte_vld_o` is high for exactly one system clock, and only after the eighth accepted falling edge of a byte. It rises three system clocks after the serial clock input falls, counting two synchroniser stages and one edge-detect register. After seven edges the output is unchanged.
- R4: After each completed byte the shift register starts fresh, so a following byte needs another eight edges. Back-to-back bytes are each received correctly.
- R5: `dat_oe_o` (1 = pull the data line low) rises in the same cycle as `byte_vld_o`. It stays high for exactly ACK_CYCLES system clocks (default 16).
- R6: `eot_o` is set when a completed byte equals 0xFF. It is cleared when a completed byte has any other value, and it changes at no other time except reset.
- R7: Falling edges of the serial clock that are detected while `dat_oe_o` is high do not shift in bits and do not count toward the next byte.
- R8: While `rst` is high on a rising edge of `clk`, the partial byte is discarded, and `byte_o`, `byte_vld_o`, `eot_o` and `dat_oe_o` are all forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock from the sender; idles low |
| ser_dat_i | input | 1 | Level read back from the shared data line |
| dat_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| byte_o | output | 8 | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| eot_o | output | 1 | Last completed byte was 0xFF |

## Verification
The case that is hardest to reach from the ports is a serial clock edge landing inside the acknowledge window, because a well-behaved sender waits for the acknowledge before it continues. The stimulus sends extra short clock pulses right after the last bit of a byte, timed so that their detected falling edges fall while the driver is still enabled. It then checks that the next complete byte is received intact. A reset in the middle of a byte is also applied after only a few bits, to confirm that the receiver comes back into step.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = BYTE_W + 1;

  // marker bit loaded at the bottom of an empty register
  function automatic logic [REG_W-1:0] srx_empty();
    return {{(REG_W-1){1'b0}}, 1'b1};
  endfunction

  // move earlier bits up one place, new bit in at bit 0
  function automatic logic [REG_W-1:0] srx_push(input logic [REG_W-1:0] cur, input logic b);
    return {cur[REG_W-2:0], b};
  endfunction

  // marker has reached the top: eight data bits are below it
  function automatic logic srx_full(input logic [REG_W-1:0] r);
    return r[REG_W-1];
  endfunction

  function automatic logic srx_is_last(input logic [BYTE_W-1:0] b);
    return &b;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              done_w,
  output logic [BYTE_W-1:0] byte_q,
  output logic              vld_q,
  output logic              eot_q
);
  logic [REG_W-1:0] sreg_q;
  logic [REG_W-1:0] nxt_w;

  assign nxt_w  = srx_push(sreg_q, bit_in);
  assign done_w = shift_en && srx_full(nxt_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= srx_empty();
      byte_q <= '0;
      vld_q  <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (done_w) begin
        sreg_q <= srx_empty();
        byte_q <= nxt_w[BYTE_W-1:0];
        vld_q  <= 1'b1;
        eot_q  <= srx_is_last(nxt_w[BYTE_W-1:0]);
      end else if (shift_en) begin
        sreg_q <= nxt_w;
      end
    end
  end

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sreg_q));
  // R2
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && !$past(rst)) |-> $stable(byte_q));
  // R6
  eot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && !$past(rst)) |-> $stable(eot_q));
endmodule

// File: rtl/srx_ack.sv
module srx_ack #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= HOLD_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R5
  ack_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import srx_pkg::*;
#(
  parameter int unsigned ACK_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              dat_oe_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              eot_o
);
  logic [1:0] sync_w;
  logic       sclk_s, sdat_s, sclk_d;
  logic       fall_w, shift_en_w, done_w, ack_busy_w;

  srx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk_i, ser_dat_i}),
    .q   (sync_w)
  );
  assign sclk_s = sync_w[1];
  assign sdat_s = sync_w[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign fall_w     = sclk_d && !sclk_s;
  assign shift_en_w = fall_w && !ack_busy_w;

  srx_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en_w),
    .bit_in   (sdat_s),
    .done_w   (done_w),
    .byte_q   (byte_o),
    .vld_q    (byte_vld_o),
    .eot_q    (eot_o)
  );

  srx_ack #(.HOLD(ACK_CYCLES)) u_ack (
    .clk  (clk),
    .rst  (rst),
    .load (done_w),
    .busy (ack_busy_w)
  );

  assign dat_oe_o = ack_busy_w;

  // R5
  ack_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> dat_oe_o);
  // R7
  no_byte_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    dat_oe_o |=> !byte_vld_o);
endmodule

// File: tb/serial_byte_rx_tb.sv
module serial_byte_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACK = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       dat_oe;
  logic [7:0] byte_o;
  logic       byte_vld;
  logic       eot;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_byte_rx #(.ACK_CYCLES(ACK)) u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .dat_oe_o(dat_oe), .byte_o(byte_o), .byte_vld_o(byte_vld), .eot_o(eot)
  );

  // behavioural reference model: bit counter, integer accumulator
  int m_c1, m_c2, m_cprev, m_d1, m_d2;
  int m_acc, m_bits, m_ack;
  int e_byte, e_vld, e_eot;

  always @(posedge clk) begin
    if (rst) begin
      m_c1 = 0; m_c2 = 0; m_cprev = 0; m_d1 = 0; m_d2 = 0;
      m_acc = 0; m_bits = 0; m_ack = 0;
      e_byte = 0; e_vld = 0; e_eot = 0;
    end else begin
      e_vld = 0;
      if (m_cprev == 1 && m_c2 == 0 && m_ack == 0) begin
        m_acc = ((m_acc * 2) + m_d2) % 256;
        m_bits++;
        if (m_bits == 8) begin
          e_byte = m_acc; e_vld = 1; e_eot = (m_acc == 255);
          m_acc = 0; m_bits = 0; m_ack = ACK;
        end
      end else if (m_ack > 0) begin
        m_ack--;
      end
      m_cprev = m_c2; m_c2 = m_c1; m_c1 = int'(ser_clk);
      m_d2 = m_d1; m_d1 = int'(ser_dat);
    end
  end

  // per-clock comparison plus observation counters
  int vld_cnt = 0;
  int cap_byte = 0;
  int oe_run = 0;
  int last_run = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 byte_o model", int'(byte_o), e_byte);
      check("R3 byte_vld_o model", int'(byte_vld), e_vld);
      check("R6 eot_o model", int'(eot), e_eot);
      check("R5 dat_oe_o model", int'(dat_oe), (m_ack != 0) ? 1 : 0);
      if (byte_vld) begin vld_cnt++; cap_byte = int'(byte_o); end
      if (dat_oe) oe_run++;
      else if (oe_run > 0) begin last_run = oe_run; oe_run = 0; end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: wrong level while low, correct level while high, flipped after fall (R1)
  task automatic send_bit(input logic b);
    ser_dat = ~b;
    wait_clk(2);
    ser_clk = 1'b1;
    wait_clk(2);
    ser_dat = b;
    wait_clk(3);
    ser_clk = 1'b0;
    wait_clk(4);
    ser_dat = ~b;
    wait_clk(1);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic send_byte(input logic [7:0] v);
    send_bits(v, 8);
    wait_clk(ACK + 4);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] v, input int vbefore);
    check(req, cap_byte, int'(v));
    check(req, vld_cnt - vbefore, 1);
  endtask

  initial begin
    int v0;
    wait_clk(3);
    @(posedge clk); #1 rst = 1'b0;
    wait_clk(1);
    // R8 reset state
    check("R8 byte_o reset", int'(byte_o), 0);
    check("R8 vld reset", int'(byte_vld), 0);
    check("R8 eot reset", int'(eot), 0);
    check("R8 oe reset", int'(dat_oe), 0);

    // R2 bit ordering, R1 data glitches ignored
    v0 = vld_cnt; send_byte(8'hA5); expect_byte("R2 0xA5", 8'hA5, v0);
    v0 = vld_cnt; send_byte(8'h80); expect_byte("R2 0x80 first bit to bit7", 8'h80, v0);
    v0 = vld_cnt; send_byte(8'h01); expect_byte("R1 0x01 last bit to bit0", 8'h01, v0);
    // R5 acknowledge width
    check("R5 ack width", last_run, ACK);

    // R4 back-to-back bytes
    v0 = vld_cnt; send_bits(8'h12, 8); wait_clk(ACK + 1);
    send_byte(8'h34);
    check("R4 two bytes", vld_cnt - v0, 2);
    check("R4 second byte", cap_byte, 8'h34);

    // R3 seven edges do nothing, eighth completes
    v0 = vld_cnt; send_bits(8'hC6, 7); wait_clk(6);
    check("R3 no vld after 7 edges", vld_cnt - v0, 0);
    check("R3 byte_o held", int'(byte_o), 8'h34);
    send_bit(1'b1); wait_clk(ACK + 4);
    expect_byte("R3 eighth edge", 8'hC7, v0);

    // R6 end-of-transfer flag set and cleared
    send_byte(8'hFF);
    check("R6 eot set", int'(eot), 1);
    send_byte(8'h00);
    check("R6 eot cleared", int'(eot), 0);

    // R7 edges during the acknowledge are ignored
    v0 = vld_cnt;
    send_bits(8'h96, 8);
    wait_clk(1);
    for (int p = 0; p < 2; p++) begin
      ser_dat = 1'b1; ser_clk = 1'b1; wait_clk(2);
      ser_clk = 1'b0; wait_clk(2);
    end
    check("R7 oe still high", int'(dat_oe), 1);
    wait_clk(ACK);
    send_byte(8'h3C);
    check("R7 bytes after extra edges", vld_cnt - v0, 2);
    check("R7 clean byte", cap_byte, 8'h3C);

    // R8 reset mid-byte resynchronises
    send_bits(8'hE0, 3);
    @(posedge clk); #1 rst = 1'b1;
    wait_clk(2);
    @(posedge clk); #1 rst = 1'b0;
    wait_clk(1);
    check("R8 byte_o cleared", int'(byte_o), 0);
    v0 = vld_cnt; send_byte(8'h5A); expect_byte("R8 resync byte", 8'h5A, v0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule